// File: doc/BRIEF.md
# Redundant Store Check Buffer

This block sits between two copies of the same program that run in lock-step with a lag, and the memory system below them. The leading copy places the address and data of each store it commits into an ordered buffer. When the trailing copy later commits its own version of that store, the block compares the trailing address and data with the oldest buffered entry. If both fields agree, the block sends exactly one write toward the cache and retires the entry. If either field disagrees, a transient fault has corrupted one of the copies. The write is then withheld, the entry stays in place and a sticky fault indication is raised.

Only stores pass through this buffer. Instructions that produce register results are not compared here. The fault indication reports which buffer slot held the disputed store and whether its address differed or only its data. Recovery logic outside the block uses this, pulses a clear input, and lets the trailing side present the store again.

Top module: `store_check_buf`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty: `lead_ready`=1, `trail_ready`=0, `fault_flag`=0 and `cache_wr_en`=0.
- R2: A push is accepted on a clock edge where `lead_valid` and `lead_ready` are both high. `lead_ready` is low while DEPTH entries are held. A push offered while `lead_ready` is low is not stored, and no accepted entry is ever lost.
- R3: When a trailing check is accepted (`trail_valid` and `trail_ready` high) and both address and data equal the oldest entry, `cache_wr_en` is high for exactly the following cycle, carrying that address and data, and the entry is removed.
- R4: Trailing stores are matched against entries strictly in the order the leading side pushed them.
- R5: When an accepted check differs in address or data, `fault_flag` is high from the next cycle. No cache write is issued, and the disputed entry stays at the head, where a later correct check releases it.
- R6: `fault_addr_miss` is 1 when the address differed (whether or not the data also differed) and 0 when only the data differed.
- R7: `fault_idx` gives the slot of the disputed entry. After reset, slots are filled in push order 0, 1, ..., DEPTH-1 and then wrap back to 0.
- R8: `fault_flag`, `fault_idx` and `fault_addr_miss` hold until `fault_clr` is pulsed. While the flag is set, `trail_ready` is 0 and no check is taken.
- R9: With the buffer empty, `trail_ready` is 0 and a presented trailing store causes neither a cache write nor a fault.
- R10: A push and a matching check in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lead_valid | input | 1 | Leading side offers a committed store |
| lead_addr | input | ADDR_W | Leading store address |
| lead_data | input | DATA_W | Leading store data |
| lead_ready | output | 1 | Buffer can take a push |
| trail_valid | input | 1 | Trailing side presents a committed store |
| trail_addr | input | ADDR_W | Trailing store address |
| trail_data | input | DATA_W | Trailing store data |
| trail_ready | output | 1 | A check is taken this cycle if trail_valid is high |
| cache_wr_en | output | 1 | One verified store toward the cache |
| cache_wr_addr | output | ADDR_W | Verified store address |
| cache_wr_data | output | DATA_W | Verified store data |
| fault_flag | output | 1 | Sticky mismatch indication |
| fault_idx | output | IDX_W | Slot index of the disputed entry |
| fault_addr_miss | output | 1 | 1: address differed, 0: only data differed |
| fault_clr | input | 1 | Pulse to clear the fault indication |

## Verification
The comparison is exercised with identical store pairs, pairs that differ only in data, pairs that differ only in address, and pairs that differ in both. Together these separate a release from a withheld write and show how the address-versus-data bit is chosen. Pushes and checks are also tried back to back, in the same cycle, and against a full buffer, which shows that ordering is kept and that nothing is dropped or duplicated. Repeated mismatches after the slot pointer wraps confirm the reported index. Checks presented to an empty buffer and a reset taken mid-use show that nothing leaks toward the cache.

// File: rtl/scb_pkg.sv
// Package: shared definitions for the redundant store check buffer.
// Assumes nothing beyond IEEE 1800-2017 synthesis support.
package scb_pkg;
    // Encoding of the fault kind bit reported at the port
    typedef enum logic {
        MISS_DATA = 1'b0,
        MISS_ADDR = 1'b1
    } miss_kind_e;
endpackage

// File: rtl/scb_fifo.sv
// Module: scb_fifo
// Ordered store buffer holding {address,data} entries from the leading side.
// Assumes callers never push while full or pop while empty; exposes the head
// entry and its slot index combinationally.
module scb_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [IDX_W-1:0] head_idx,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     slot_q [DEPTH];
    logic [IDX_W-1:0] wr_ptr;
    logic [IDX_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // One register per slot, written when the write pointer selects it
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == IDX_W'(s)) slot_q[s] <= din;
        end
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head     = slot_q[rd_ptr];
    assign head_idx = rd_ptr;
    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
endmodule

// File: rtl/scb_cmp.sv
// Module: scb_cmp
// Field-wise comparison of the buffered store against the trailing store.
// Purely combinational; assumes both operands are stable within the cycle.
module scb_cmp #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] exp_addr,
    input  logic [DATA_W-1:0] exp_data,
    input  logic [ADDR_W-1:0] got_addr,
    input  logic [DATA_W-1:0] got_data,
    output logic              addr_diff,
    output logic              data_diff
);
    // Independent inequality per field so the fault kind can be reported
    always_comb begin
        addr_diff = (exp_addr != got_addr);
        data_diff = (exp_data != got_data);
    end
endmodule

// File: rtl/store_check_buf.sv
// Module: store_check_buf (top)
// Buffers leading-side stores and releases one verified copy to the cache
// when the trailing copy matches the oldest entry; latches a sticky fault on
// any mismatch. Assumes both sides commit stores in program order.
module store_check_buf
    import scb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int ENT_W = ADDR_W + DATA_W,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lead_valid,
    input  logic [ADDR_W-1:0] lead_addr,
    input  logic [DATA_W-1:0] lead_data,
    output logic              lead_ready,
    input  logic              trail_valid,
    input  logic [ADDR_W-1:0] trail_addr,
    input  logic [DATA_W-1:0] trail_data,
    output logic              trail_ready,
    output logic              cache_wr_en,
    output logic [ADDR_W-1:0] cache_wr_addr,
    output logic [DATA_W-1:0] cache_wr_data,
    output logic              fault_flag,
    output logic [IDX_W-1:0]  fault_idx,
    output logic              fault_addr_miss,
    input  logic              fault_clr
);
    logic              fifo_full;
    logic              fifo_empty;
    logic [ENT_W-1:0]  head_ent;
    logic [IDX_W-1:0]  head_idx;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic              addr_diff;
    logic              data_diff;
    logic              push_fire;
    logic              check_fire;
    logic              is_match;
    logic              pop_fire;
    miss_kind_e        miss_kind;

    assign head_addr = head_ent[ENT_W-1:DATA_W];
    assign head_data = head_ent[DATA_W-1:0];

    // Handshake and event decode
    always_comb begin
        lead_ready  = !fifo_full;
        trail_ready = !fifo_empty && !fault_flag;
        push_fire   = lead_valid && !fifo_full;
        check_fire  = trail_valid && trail_ready;
        is_match    = !addr_diff && !data_diff;
        pop_fire    = check_fire && is_match;
        miss_kind   = addr_diff ? MISS_ADDR : MISS_DATA;
    end

    scb_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_fire),
        .din      ({lead_addr, lead_data}),
        .pop      (pop_fire),
        .head     (head_ent),
        .head_idx (head_idx),
        .full     (fifo_full),
        .empty    (fifo_empty)
    );

    scb_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .exp_addr  (head_addr),
        .exp_data  (head_data),
        .got_addr  (trail_addr),
        .got_data  (trail_data),
        .addr_diff (addr_diff),
        .data_diff (data_diff)
    );

    // Registered cache write port: one beat per verified pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cache_wr_en   <= 1'b0;
            cache_wr_addr <= '0;
            cache_wr_data <= '0;
        end else begin
            cache_wr_en <= pop_fire;
            if (pop_fire) begin
                cache_wr_addr <= head_addr;
                cache_wr_data <= head_data;
            end
        end
    end

    // Sticky fault record, cleared only by the clear pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_flag      <= 1'b0;
            fault_idx       <= '0;
            fault_addr_miss <= 1'b0;
        end else if (check_fire && !is_match) begin
            fault_flag      <= 1'b1;
            fault_idx       <= head_idx;
            fault_addr_miss <= (miss_kind == MISS_ADDR);
        end else if (fault_clr) begin
            fault_flag      <= 1'b0;
        end
    end
endmodule

// File: rtl/scb_chk.sv
// Module: scb_chk
// Temporal checks on store_check_buf, attached by the bind below.
// Assumes reset is asserted at time zero.
module scb_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trail_valid,
    input logic              trail_ready,
    input logic [ADDR_W-1:0] trail_addr,
    input logic [DATA_W-1:0] trail_data,
    input logic [ADDR_W-1:0] head_addr,
    input logic [DATA_W-1:0] head_data,
    input logic              fifo_empty,
    input logic              cache_wr_en,
    input logic [ADDR_W-1:0] cache_wr_addr,
    input logic [DATA_W-1:0] cache_wr_data,
    input logic              fault_flag,
    input logic [IDX_W-1:0]  fault_idx,
    input logic              fault_addr_miss,
    input logic              fault_clr
);
    // R3
    match_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_valid && trail_ready && trail_addr == head_addr && trail_data == head_data)
        |=> (cache_wr_en && cache_wr_addr == $past(trail_addr) && cache_wr_data == $past(trail_data)));

    // R5
    mismatch_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_valid && trail_ready && (trail_addr != head_addr || trail_data != head_data))
        |=> (fault_flag && !cache_wr_en));

    // R5
    no_write_in_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> !cache_wr_en);

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !fault_clr) |=> (fault_flag && $stable(fault_idx) && $stable(fault_addr_miss)));

    // R9
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_valid && fifo_empty && !fault_flag) |=> (!cache_wr_en && !fault_flag));
endmodule

bind store_check_buf scb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .trail_valid     (trail_valid),
    .trail_ready     (trail_ready),
    .trail_addr      (trail_addr),
    .trail_data      (trail_data),
    .head_addr       (head_addr),
    .head_data       (head_data),
    .fifo_empty      (fifo_empty),
    .cache_wr_en     (cache_wr_en),
    .cache_wr_addr   (cache_wr_addr),
    .cache_wr_data   (cache_wr_data),
    .fault_flag      (fault_flag),
    .fault_idx       (fault_idx),
    .fault_addr_miss (fault_addr_miss),
    .fault_clr       (fault_clr)
);

// File: tb/store_check_buf_tb.sv
`timescale 1ns/1ps
// Bench: vector table walk, then directed ordering, full, empty, wrap and reset tests.
module store_check_buf_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int DEPTH = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lead_valid = 1'b0;
    logic [AW-1:0] lead_addr = '0;
    logic [DW-1:0] lead_data = '0;
    logic lead_ready;
    logic trail_valid = 1'b0;
    logic [AW-1:0] trail_addr = '0;
    logic [DW-1:0] trail_data = '0;
    logic trail_ready;
    logic cache_wr_en;
    logic [AW-1:0] cache_wr_addr;
    logic [DW-1:0] cache_wr_data;
    logic fault_flag;
    logic [IW-1:0] fault_idx;
    logic fault_addr_miss;
    logic fault_clr = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    int popped = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    store_check_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lead_valid(lead_valid), .lead_addr(lead_addr), .lead_data(lead_data), .lead_ready(lead_ready),
        .trail_valid(trail_valid), .trail_addr(trail_addr), .trail_data(trail_data), .trail_ready(trail_ready),
        .cache_wr_en(cache_wr_en), .cache_wr_addr(cache_wr_addr), .cache_wr_data(cache_wr_data),
        .fault_flag(fault_flag), .fault_idx(fault_idx), .fault_addr_miss(fault_addr_miss),
        .fault_clr(fault_clr)
    );

    // {lead_addr, lead_data, trail_addr, trail_data, expect_match, expect_addr_miss}
    localparam logic [129:0] VEC [6] = '{
        {32'h0000_1000, 32'hAAAA_0001, 32'h0000_1000, 32'hAAAA_0001, 1'b1, 1'b0},
        {32'h0000_1004, 32'h1234_5678, 32'h0000_1004, 32'h1234_5678, 1'b1, 1'b0},
        {32'h0000_1008, 32'h0000_00FF, 32'h0000_1008, 32'h0000_00FE, 1'b0, 1'b0},
        {32'h0000_100C, 32'h0000_CAFE, 32'h0000_100D, 32'h0000_CAFE, 1'b0, 1'b1},
        {32'h0000_1010, 32'h0000_5555, 32'h0000_2010, 32'h0000_0000, 1'b0, 1'b1},
        {32'h0000_1014, 32'hFFFF_FFFF, 32'h0000_1014, 32'hFFFF_FFFF, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_push(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        lead_valid = 1'b1; lead_addr = a; lead_data = d;
        @(negedge clk);
        lead_valid = 1'b0;
    endtask

    task automatic do_trail(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        trail_valid = 1'b1; trail_addr = a; trail_data = d;
        @(negedge clk);
        trail_valid = 1'b0;
    endtask

    task automatic expect_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        chk(cache_wr_en == 1'b1, req, 64'(cache_wr_en), 64'd1);
        chk(cache_wr_addr == a, req, 64'(cache_wr_addr), 64'(a));
        chk(cache_wr_data == d, req, 64'(cache_wr_data), 64'(d));
        popped++;
    endtask

    task automatic expect_fault(input bit amiss, input string req);
        chk(fault_flag == 1'b1, req, 64'(fault_flag), 64'd1);
        chk(cache_wr_en == 1'b0, req, 64'(cache_wr_en), 64'd0);
        chk(fault_idx == IW'(popped % DEPTH), {req, "/R7"}, 64'(fault_idx), 64'(popped % DEPTH));
        chk(fault_addr_miss == amiss, {req, "/R6"}, 64'(fault_addr_miss), 64'(amiss));
    endtask

    task automatic clear_fault();
        @(negedge clk); fault_clr = 1'b1;
        @(negedge clk); fault_clr = 1'b0;
    endtask

    task automatic check_reset_state(input string req);
        chk(lead_ready == 1'b1, req, 64'(lead_ready), 64'd1);
        chk(trail_ready == 1'b0, req, 64'(trail_ready), 64'd0);
        chk(fault_flag == 1'b0, req, 64'(fault_flag), 64'd0);
        chk(cache_wr_en == 1'b0, req, 64'(cache_wr_en), 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R1 reset");

        // Vector walk: R3 matches, R5/R6/R7 mismatches with clear and retry (R8)
        for (int i = 0; i < 6; i++) begin
            logic [129:0] v;
            v = VEC[i];
            do_push(v[129:98], v[97:66]);
            do_trail(v[65:34], v[33:2]);
            if (v[1]) begin
                expect_write(v[129:98], v[97:66], "R3 match write");
                @(negedge clk);
                chk(cache_wr_en == 1'b0, "R3 single beat", 64'(cache_wr_en), 64'd0);
            end else begin
                expect_fault(v[0], "R5 mismatch");
                @(negedge clk);
                chk(trail_ready == 1'b0, "R8 blocked in fault", 64'(trail_ready), 64'd0);
                chk(fault_flag == 1'b1, "R8 sticky", 64'(fault_flag), 64'd1);
                clear_fault();
                chk(fault_flag == 1'b0, "R8 cleared", 64'(fault_flag), 64'd0);
                do_trail(v[129:98], v[97:66]);
                expect_write(v[129:98], v[97:66], "R5 head retained");
            end
        end

        // R10: push and matching check in the same cycle
        do_push(32'h0000_3000, 32'h0000_0030);
        @(negedge clk);
        lead_valid = 1'b1; lead_addr = 32'h0000_3004; lead_data = 32'h0000_0034;
        trail_valid = 1'b1; trail_addr = 32'h0000_3000; trail_data = 32'h0000_0030;
        @(negedge clk);
        lead_valid = 1'b0; trail_valid = 1'b0;
        expect_write(32'h0000_3000, 32'h0000_0030, "R10 concurrent check");
        do_trail(32'h0000_3004, 32'h0000_0034);
        expect_write(32'h0000_3004, 32'h0000_0034, "R10 concurrent push kept");

        // R2: fill, refused push, drain in order (R4)
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            lead_valid = 1'b1; lead_addr = 32'h4000 + AW'(k * 4); lead_data = 32'h100 + DW'(k);
        end
        @(negedge clk);
        lead_valid = 1'b0;
        chk(lead_ready == 1'b0, "R2 full backpressure", 64'(lead_ready), 64'd0);
        lead_valid = 1'b1; lead_addr = 32'hDEAD; lead_data = 32'hBEEF;
        @(negedge clk);
        lead_valid = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            do_trail(32'h4000 + AW'(k * 4), 32'h100 + DW'(k));
            expect_write(32'h4000 + AW'(k * 4), 32'h100 + DW'(k), "R4 order");
        end
        chk(trail_ready == 1'b0, "R2 refused push not stored", 64'(trail_ready), 64'd0);

        // R9: check against empty buffer
        @(negedge clk);
        trail_valid = 1'b1; trail_addr = 32'h0000_5000; trail_data = 32'h0000_0001;
        @(negedge clk);
        @(negedge clk);
        trail_valid = 1'b0;
        chk(cache_wr_en == 1'b0, "R9 empty no write", 64'(cache_wr_en), 64'd0);
        chk(fault_flag == 1'b0, "R9 empty no fault", 64'(fault_flag), 64'd0);

        // R7: slot index across the wrap point
        for (int k = 0; k < 3; k++) begin
            do_push(32'h6000 + AW'(k), 32'h0000_0070);
            do_trail(32'h6000 + AW'(k), 32'h0000_0071);
            expect_fault(1'b0, "R7 wrap index");
            clear_fault();
            do_trail(32'h6000 + AW'(k), 32'h0000_0070);
            expect_write(32'h6000 + AW'(k), 32'h0000_0070, "R7 retry");
        end

        // R1: reset while holding an entry and a fault
        do_push(32'h0000_7000, 32'h0000_0007);
        do_trail(32'h0000_7001, 32'h0000_0007);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R1 reset mid-use");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule